// File: doc/BRIEF.md
# Strobe-Coherent Probe Register Bridge

This block connects a host-side register bus with 16-bit data words to a group of user-logic probes that may be wider than one bus word. Sense probes carry values from user logic toward the host. Drive probes carry values from the host into user logic. Every probe sits behind a buffer, so user logic never sees a half-written value and the host never reads a half-updated one.

The host writes new drive values into their buffer words, one bus word at a time. It then raises the strobe register and later clears it. The rising edge of the strobe is synchronized into the user clock. On that edge, every drive probe takes its buffered value in the same cycle, and every sense probe is captured. The captured sense values cross back to the bus clock through a second register stage. After that the host can read all the words of a wide sense probe, and they all belong to the same instant. The two clocks may be unrelated.

Register map with default parameters (two 24-bit sense probes, two 20-bit drive probes):

- Address 0 is the strobe.
- Addresses 1 to 4 hold the sense probes.
- Addresses 5 to 8 hold the drive probes.
- Each probe takes two consecutive addresses. The lower address holds bits 15:0 and the higher address holds the remaining upper bits.

Top module: `probe_bridge`

## Requirements
- R1: After reset, all drive-probe outputs are zero. Every drive buffer word reads as 0x0000, and the strobe register reads as 0x0000.
- R2: A host write to a drive buffer word can be read back at once with the value written. The drive-probe outputs stay unchanged until the next strobe rising edge.
- R3: After a strobe rising edge, every bit of every drive probe takes its buffered value in one user-clock cycle. Drive outputs change at no other time.
- R4: The strobe rising edge captures all sense probes together. Later changes on the sense inputs do not alter what the host reads until the next strobe rising edge.
- R5: Sense words are read-only. A host write to a sense address leaves its read value unchanged.
- R6: A probe wider than 16 bits takes consecutive addresses, with bits 15:0 at the lower address. Bits of an upper word beyond the probe width read as zero, and writes to those bits are discarded. With the defaults, sense probe i uses addresses 1+2i (low word) and 2+2i (high word, bits 7:0). Drive probe j uses addresses 5+2j (low word) and 6+2j (high word, bits 3:0).
- R7: Only a 0-to-1 transition of strobe bit 0 transfers data. While the strobe stays at one, new buffer writes do not reach the drive outputs. The strobe must stay high for at least three user-clock cycles.
- R8: A read request returns bus_rvalid high, with its data, exactly one bus clock later. bus_rvalid is low in every other cycle.
- R9: A read of an address beyond the last probe word returns 0x0000.
- R10: The strobe register at address 0 reads back the last value written to bit 0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read request for one cycle |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| usr_clk | input | 1 | User logic clock |
| usr_rst | input | 1 | Synchronous active-high reset, user domain |
| sense_in | input | NUM_IN*IN_W | Packed sense probes, probe 0 in the low bits |
| drive_out | output | NUM_OUT*OUT_W | Packed drive probes, probe 0 in the low bits |

## Verification
A table of four patterns is driven through the full write-strobe-read flow:

- all zeros against all ones in the two halves;
- alternating bits;
- only the top bit of a probe set;
- a value that is ones only in its low word.

Together these show whether the two words of each probe are stitched together in the right order. They also show whether the probes are swapped, and whether an upper-word mask cuts off valid bits.

Directed cases cover the following:

- changing the sense inputs after a capture;
- writing buffer words while the strobe is held high;
- writing to read-only and unmapped addresses.

Each of these separates a live path from a buffered one.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int WORD_W = 16;

  function automatic int words_for(int bits);
    return (bits + WORD_W - 1) / WORD_W;
  endfunction

  // mask of the valid bits in one bus word of a probe
  function automatic logic [WORD_W-1:0] word_mask(int bits_left);
    if (bits_left >= WORD_W) return {WORD_W{1'b1}};
    return WORD_W'((32'd1 << bits_left) - 32'd1);
  endfunction
endpackage

// File: rtl/pb_bit_sync.sv
module pb_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], d};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/pb_user_side.sv
module pb_user_side #(
  parameter int IN_BITS  = 48,
  parameter int OUT_BITS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [OUT_BITS-1:0] drive_buf,
  input  logic [IN_BITS-1:0]  sense_in,
  output logic [OUT_BITS-1:0] drive_out,
  output logic [IN_BITS-1:0]  sense_cap
);
  logic [OUT_BITS-1:0] drive_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_stage <= '0;
      drive_out   <= '0;
      sense_cap   <= '0;
    end else begin
      drive_stage <= drive_buf;
      if (load) begin
        drive_out <= drive_stage;
        sense_cap <= sense_in;
      end
    end
  end
endmodule

// File: rtl/pb_regfile.sv
module pb_regfile
  import pb_pkg::*;
#(
  parameter int NUM_IN  = 2,
  parameter int IN_W    = 24,
  parameter int NUM_OUT = 2,
  parameter int OUT_W   = 20,
  parameter int ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic                     rd,
  output logic [WORD_W-1:0]        rdata,
  output logic                     rvalid,
  output logic                     strobe_q,
  output logic [NUM_OUT*OUT_W-1:0] drive_buf,
  input  logic [NUM_IN*IN_W-1:0]   sense_cap
);
  localparam int IN_WORDS  = words_for(IN_W);
  localparam int OUT_WORDS = words_for(OUT_W);
  localparam int IN_REGS   = NUM_IN * IN_WORDS;
  localparam int OUT_REGS  = NUM_OUT * OUT_WORDS;
  localparam int IN_BASE   = 1;
  localparam int OUT_BASE  = IN_BASE + IN_REGS;
  localparam int IN_PW     = IN_WORDS * WORD_W;
  localparam int OUT_PW    = OUT_WORDS * WORD_W;

  logic [WORD_W-1:0]        out_word [OUT_REGS];
  logic [OUT_REGS*WORD_W-1:0] out_pad;
  logic [NUM_IN*IN_W-1:0]   sense_hold;
  logic [IN_REGS*WORD_W-1:0]  in_pad;
  logic [WORD_W-1:0]        rword;

  // second synchronizer stage for captured sense values
  always_ff @(posedge clk) begin
    if (rst) sense_hold <= '0;
    else     sense_hold <= sense_cap;
  end

  for (genvar k = 0; k < OUT_REGS; k++) begin : g_opad
    assign out_pad[k*WORD_W +: WORD_W] = out_word[k];
  end
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_obuf
    assign drive_buf[j*OUT_W +: OUT_W] = out_pad[j*OUT_PW +: OUT_W];
  end
  for (genvar i = 0; i < NUM_IN; i++) begin : g_ipad
    assign in_pad[i*IN_PW +: IN_PW] = IN_PW'(sense_hold[i*IN_W +: IN_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      for (int k = 0; k < OUT_REGS; k++) out_word[k] <= '0;
    end else if (wr) begin
      if (int'(addr) == 0) strobe_q <= wdata[0];
      for (int k = 0; k < OUT_REGS; k++) begin
        if (int'(addr) == OUT_BASE + k)
          out_word[k] <= wdata & word_mask(OUT_W - (k % OUT_WORDS) * WORD_W);
      end
    end
  end

  always_comb begin
    rword = '0;
    if (int'(addr) == 0) rword = {{(WORD_W-1){1'b0}}, strobe_q};
    for (int k = 0; k < IN_REGS; k++)
      if (int'(addr) == IN_BASE + k) rword = in_pad[k*WORD_W +: WORD_W];
    for (int k = 0; k < OUT_REGS; k++)
      if (int'(addr) == OUT_BASE + k) rword = out_word[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rword;
    end
  end
endmodule

// File: rtl/probe_bridge.sv
module probe_bridge
  import pb_pkg::*;
#(
  parameter int NUM_IN      = 2,
  parameter int IN_W        = 24,
  parameter int NUM_OUT     = 2,
  parameter int OUT_W       = 20,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     bus_clk,
  input  logic                     bus_rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [15:0]              bus_wdata,
  input  logic                     bus_rd,
  output logic [15:0]              bus_rdata,
  output logic                     bus_rvalid,
  input  logic                     usr_clk,
  input  logic                     usr_rst,
  input  logic [NUM_IN*IN_W-1:0]   sense_in,
  output logic [NUM_OUT*OUT_W-1:0] drive_out
);
  logic                     strobe_q;
  logic                     load_pulse;
  logic [NUM_OUT*OUT_W-1:0] drive_buf;
  logic [NUM_IN*IN_W-1:0]   sense_cap;

  pb_regfile #(
    .NUM_IN(NUM_IN), .IN_W(IN_W), .NUM_OUT(NUM_OUT), .OUT_W(OUT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(bus_clk), .rst(bus_rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .rdata(bus_rdata), .rvalid(bus_rvalid), .strobe_q(strobe_q),
    .drive_buf(drive_buf), .sense_cap(sense_cap)
  );

  pb_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(usr_clk), .rst(usr_rst), .d(strobe_q), .rise(load_pulse)
  );

  pb_user_side #(.IN_BITS(NUM_IN*IN_W), .OUT_BITS(NUM_OUT*OUT_W)) u_user (
    .clk(usr_clk), .rst(usr_rst), .load(load_pulse), .drive_buf(drive_buf),
    .sense_in(sense_in), .drive_out(drive_out), .sense_cap(sense_cap)
  );
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int OUT_BITS = 40
) (
  input logic                bus_clk,
  input logic                bus_rst,
  input logic                bus_rd,
  input logic                bus_rvalid,
  input logic                usr_clk,
  input logic                usr_rst,
  input logic                load_pulse,
  input logic [OUT_BITS-1:0] drive_out
);
  a_r8_rvalid_follows: assert property (@(posedge bus_clk) disable iff (bus_rst)
    bus_rd |=> bus_rvalid);

  a_r8_no_spurious_valid: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !bus_rd |=> !bus_rvalid);

  a_r3_drive_only_on_load: assert property (@(posedge usr_clk) disable iff (usr_rst)
    !$stable(drive_out) |-> $past(load_pulse));

  a_r7_single_load: assert property (@(posedge usr_clk) disable iff (usr_rst)
    load_pulse |=> !load_pulse);

  a_r1_reset_clears: assert property (@(posedge usr_clk) disable iff (usr_rst)
    $past(usr_rst) |-> drive_out == '0);
endmodule

bind probe_bridge pb_checker #(.OUT_BITS(NUM_OUT*OUT_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .usr_clk(usr_clk), .usr_rst(usr_rst), .load_pulse(load_pulse), .drive_out(drive_out)
);

// File: tb/probe_bridge_test.sv
module probe_bridge_test;
  logic        bus_clk = 0, usr_clk = 0;
  logic        bus_rst, usr_rst;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [47:0] sense_in;
  logic [39:0] drive_out;

  int checks = 0, failures = 0;

  always #5 bus_clk = ~bus_clk;
  always #7 usr_clk = ~usr_clk;

  probe_bridge uut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .usr_clk(usr_clk), .usr_rst(usr_rst), .sense_in(sense_in), .drive_out(drive_out)
  );

  // {sense0 24, sense1 24, drive0 20, drive1 20}
  localparam logic [87:0] VEC [4] = '{
    {24'h000001, 24'hFFFFFF, 20'h00000, 20'hFFFFF},
    {24'hA5A5A5, 24'h5A5A5A, 20'h12345, 20'hEDCBA},
    {24'h800000, 24'h00FFFF, 20'h80000, 20'h0FFFF},
    {24'h123456, 24'h654321, 20'h55555, 20'hAAAAA}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge bus_clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge bus_clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d, output logic v);
    @(negedge bus_clk); bus_addr = a; bus_rd = 1;
    @(negedge bus_clk); bus_rd = 0; d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d; logic v;
    bus_read(a, d, v);
    check(req, d, exp);
  endtask

  task automatic pulse_strobe();
    bus_write(8'd0, 16'd1);
    repeat (8) @(negedge bus_clk);
    bus_write(8'd0, 16'd0);
    repeat (8) @(negedge bus_clk);
  endtask

  initial begin
    repeat (100000) @(posedge bus_clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d; logic v;
    logic [39:0] held;
    bus_rst = 1; usr_rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    sense_in = 48'h0;
    repeat (4) @(negedge usr_clk);
    bus_rst = 0; usr_rst = 0;
    @(negedge bus_clk);

    // R1 reset state
    check("R1 drive_out", drive_out, 40'h0);
    read_check("R1 drive word", 8'd5, 16'h0000);
    read_check("R1 strobe", 8'd0, 16'h0000);

    // main table: write-strobe-read flow
    for (int n = 0; n < 4; n++) begin
      logic [23:0] s0, s1; logic [19:0] o0, o1;
      {s0, s1, o0, o1} = VEC[n];
      bus_write(8'd5, o0[15:0]); bus_write(8'd6, {12'h0, o0[19:16]});
      bus_write(8'd7, o1[15:0]); bus_write(8'd8, {12'h0, o1[19:16]});
      sense_in = {s1, s0};
      pulse_strobe();
      check("R3 drive all bits", drive_out, {o1, o0});
      read_check("R6 sense0 low",  8'd1, s0[15:0]);
      read_check("R6 sense0 high", 8'd2, {8'h0, s0[23:16]});
      read_check("R4 sense1 low",  8'd3, s1[15:0]);
      read_check("R4 sense1 high", 8'd4, {8'h0, s1[23:16]});
    end

    // R2 readback before strobe, outputs untouched
    held = drive_out;
    bus_write(8'd5, 16'h1234);
    read_check("R2 readback", 8'd5, 16'h1234);
    repeat (10) @(negedge bus_clk);
    check("R2 no early drive", drive_out, held);

    // R6 upper-word mask on drive
    bus_write(8'd6, 16'hFFFF);
    read_check("R6 drive high mask", 8'd6, 16'h000F);

    // R4 later sense changes not seen
    sense_in = 48'h111111_ABCDEF;
    pulse_strobe();
    check("R3 drive after strobe", drive_out[19:0], 20'hF1234);
    sense_in = 48'h999999_777777;
    repeat (10) @(negedge bus_clk);
    read_check("R4 held low", 8'd1, 16'hCDEF);
    read_check("R4 held high", 8'd2, 16'h00AB);

    // R5 sense words read-only
    bus_write(8'd1, 16'h5555);
    read_check("R5 write ignored", 8'd1, 16'hCDEF);

    // R10 strobe readback, R7 held strobe does not retransfer
    bus_write(8'd0, 16'hFFFF);
    read_check("R10 strobe set", 8'd0, 16'h0001);
    repeat (8) @(negedge bus_clk);
    held = drive_out;
    bus_write(8'd5, 16'h0BEE);
    repeat (20) @(negedge bus_clk);
    check("R7 held strobe no transfer", drive_out, held);
    bus_write(8'd0, 16'h0000);
    read_check("R10 strobe clear", 8'd0, 16'h0000);
    repeat (8) @(negedge bus_clk);
    pulse_strobe();
    check("R7 next edge transfers", drive_out[15:0], 16'h0BEE);

    // R9 unmapped addresses
    read_check("R9 addr 9", 8'd9, 16'h0000);
    read_check("R9 addr 200", 8'd200, 16'h0000);

    // R8 read latency
    bus_read(8'd5, d, v);
    check("R8 rvalid", v, 1'b1);
    @(negedge bus_clk);
    check("R8 rvalid drops", bus_rvalid, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule